// File: doc/BRIEF.md
# Multi-Word Remainder Unit

This unit reduces a long unsigned integer modulo a single word. The integer sits in a word-addressed memory, least significant word at the base address. Its word at index `i` carries the weight 2^(W·i). After a start pulse the unit walks the words from the top index down to index zero. It feeds each word through a shift-subtract divider. The partial remainder becomes the upper half of the next dividend, so only one word of state moves from step to step. When the walk ends it returns the remainder, zero-extended to twice the word width.

A second mode uses the same divider for a single double-word by single-word division. The operands arrive on input ports, and the unit returns both quotient and remainder. This mode needs the upper operand word to be below the divisor, so the quotient fits in one word. When that condition fails, an overflow flag is raised instead. A zero divisor is caught in both modes before any memory traffic starts.

Operands are captured at the start cycle. Results and flags hold their values until the next accepted start.

Top module: `wordmod_unit`

## Requirements
- R1: With `mode`=0, `rem_out` equals (sum over i of word[base+i]·2^(W·i)) mod `divisor`. The partial remainder starts from zero at every operation.
- R2: With `mode`=0 the unit issues exactly `len` reads, one cycle each with `mem_rd`=1. The addresses run base+len-1, base+len-2, … down to base. Read data is taken `RD_LAT` cycles after the read cycle.
- R3: Every divide step ends with a remainder strictly below the divisor.
- R4: The upper W bits of `rem_out` are always zero. With `mode`=0, `quot_out` reads zero after done.
- R5: With `mode`=1 and `num_hi` < `divisor`, `quot_out` and `rem_out` give the quotient and remainder of {`num_hi`,`num_lo`} / `divisor`.
- R6: With `mode`=1 and `num_hi` ≥ `divisor`, `err_ovf` is set and `done` pulses one cycle after the start cycle. Both result outputs read zero and no read is issued.
- R7: A zero `divisor` sets `err_div0` and pulses `done` one cycle after the start cycle. Both results read zero and no read is issued.
- R8: `done` is a one-cycle pulse. Counting the start cycle as cycle 0, it appears in cycle len·(W+RD_LAT+2)+1 for `mode`=0 and in cycle W+2 for `mode`=1.
- R9: With `mode`=0 and `len`=0, the unit issues no reads. `done` pulses in cycle 1 and `rem_out` is zero.
- R10: A `start` while `busy` is high is ignored. The result and completion cycle of the running operation are unchanged.
- R11: After reset, `busy`, `done`, `mem_rd`, both flags and both result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 1 | 0 = multi-word remainder, 1 = double-word divide |
| base_addr | input | AW | Address of the least significant word |
| len | input | LW | Number of words |
| divisor | input | W | Divisor word |
| num_hi | input | W | Upper dividend word for mode 1 |
| num_lo | input | W | Lower dividend word for mode 1 |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | AW | Read address |
| mem_rdata | input | W | Read data, valid RD_LAT cycles after the strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rem_out | output | 2W | Remainder, zero-extended |
| quot_out | output | W | Quotient for mode 1 |
| err_div0 | output | 1 | Divisor was zero |
| err_ovf | output | 1 | Mode-1 quotient would not fit |

## Verification
Several properties are checked on every cycle by the assertions. Each divide step must leave a remainder below the divisor. The word index must never step below zero. `done` must stay one cycle wide. An error flag may only rise together with `done`, and no read may be issued once a zero divisor has been seen. A second divide may not begin while one is running. The arithmetic itself can only be shown by the bench's scenarios: remainders against a wide-integer modulus on random operands, and the double-word table. The same holds for the descending read order and the exact completion cycle. The length-zero, length-one, divisor-one, full-scale and mid-run start cases are also scenario-only.

// File: rtl/wm_pkg.sv
package wm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_WAIT  = 3'd2,
      ST_DIV   = 3'd3,
      ST_DONE  = 3'd4
   } wm_state_t;

   typedef enum logic {
      OP_CHAIN = 1'b0,
      OP_PAIR  = 1'b1
   } wm_op_t;

endpackage

// File: rtl/wm_divstep.sv
module wm_divstep #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num_hi,
   input  logic [W-1:0] num_lo,
   input  logic [W-1:0] den,
   output logic         active,
   output logic         fin,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  r_q, q_q, d_q;
   logic [CW-1:0] cnt_q;
   logic          act_q, fin_q;
   logic [W:0]    trial, diff;
   logic          fits;

   if (W < 2) begin : g_bad_w
      $error("wm_divstep: W must be at least 2");
   end

   always_comb begin
      trial = {r_q, q_q[W-1]};
      diff  = trial - {1'b0, d_q};
      fits  = (trial >= {1'b0, d_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q   <= '0;
         q_q   <= '0;
         d_q   <= '0;
         cnt_q <= '0;
         act_q <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go) begin
            r_q   <= num_hi;
            q_q   <= num_lo;
            d_q   <= den;
            cnt_q <= CW'(W);
            act_q <= 1'b1;
         end else if (act_q) begin
            r_q   <= fits ? diff[W-1:0] : trial[W-1:0];
            q_q   <= {q_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               act_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign active = act_q;
   assign fin    = fin_q;
   assign quo    = q_q;
   assign rem    = r_q;

   // R3
   rem_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (rem < d_q));

   // R10
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !act_q);

endmodule

// File: rtl/wm_addrgen.sv
module wm_addrgen #(
   parameter int AW = 16,
   parameter int LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic [LW-1:0] len,
   input  logic          dec,
   output logic [AW-1:0] addr,
   output logic          last
);
   logic [AW-1:0] base_q;
   logic [LW-1:0] idx_q;

   if (LW > AW) begin : g_bad_lw
      $error("wm_addrgen: LW must not exceed AW");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         base_q <= base;
         idx_q  <= len - 1'b1;
      end else if (dec) begin
         idx_q  <= idx_q - 1'b1;
      end
   end

   assign addr = base_q + AW'(idx_q);
   assign last = (idx_q == '0);

   // R2
   idx_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (idx_q != '0));

endmodule

// File: rtl/wordmod_unit.sv
module wordmod_unit #(
   parameter int W      = 16,
   parameter int AW     = 16,
   parameter int LW     = 16,
   parameter int RD_LAT = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            mode,
   input  logic [AW-1:0]   base_addr,
   input  logic [LW-1:0]   len,
   input  logic [W-1:0]    divisor,
   input  logic [W-1:0]    num_hi,
   input  logic [W-1:0]    num_lo,
   output logic            mem_rd,
   output logic [AW-1:0]   mem_addr,
   input  logic [W-1:0]    mem_rdata,
   output logic            busy,
   output logic            done,
   output logic [2*W-1:0]  rem_out,
   output logic [W-1:0]    quot_out,
   output logic            err_div0,
   output logic            err_ovf
);
   import wm_pkg::*;

   localparam int RW = 2 * W;

   if (RD_LAT < 1) begin : g_bad_lat
      $error("wordmod_unit: RD_LAT must be at least 1");
   end

   wm_state_t     st_q;
   wm_op_t        op_q;
   logic [W-1:0]  dv_q, run_q, quot_q;
   logic [RW-1:0] rem_q;
   logic          e0_q, eo_q;

   logic          idle, accept, go, fin, last, ag_load, ag_dec, rvalid;
   logic [W-1:0]  dq_quo, dq_rem, d_hi, d_lo, d_den;
   logic          dq_active;

   // read-data valid tracker, one stage per cycle of read latency
   logic [RD_LAT-1:0] vld_q;
   for (genvar i = 0; i < RD_LAT; i++) begin : g_vld
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld_q[0] <= 1'b0;
            else        vld_q[0] <= mem_rd;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld_q[i] <= 1'b0;
            else        vld_q[i] <= vld_q[i-1];
         end
      end
   end
   assign rvalid = vld_q[RD_LAT-1];

   always_comb begin
      idle    = (st_q == ST_IDLE);
      accept  = idle && start;
      go      = (accept && mode && (divisor != '0) && (num_hi < divisor)) ||
                ((st_q == ST_WAIT) && rvalid);
      d_hi    = idle ? num_hi  : run_q;
      d_lo    = idle ? num_lo  : mem_rdata;
      d_den   = idle ? divisor : dv_q;
      ag_load = accept && !mode;
      ag_dec  = (st_q == ST_DIV) && fin && (op_q == OP_CHAIN) && !last;
   end

   wm_divstep #(.W(W)) i_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .num_hi (d_hi),
      .num_lo (d_lo),
      .den    (d_den),
      .active (dq_active),
      .fin    (fin),
      .quo    (dq_quo),
      .rem    (dq_rem)
   );

   wm_addrgen #(.AW(AW), .LW(LW)) i_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ag_load),
      .base  (base_addr),
      .len   (len),
      .dec   (ag_dec),
      .addr  (mem_addr),
      .last  (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         op_q   <= OP_CHAIN;
         dv_q   <= '0;
         run_q  <= '0;
         quot_q <= '0;
         rem_q  <= '0;
         e0_q   <= 1'b0;
         eo_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               op_q   <= wm_op_t'(mode);
               dv_q   <= divisor;
               run_q  <= '0;
               quot_q <= '0;
               rem_q  <= '0;
               e0_q   <= 1'b0;
               eo_q   <= 1'b0;
               if (divisor == '0) begin
                  e0_q <= 1'b1;
                  st_q <= ST_DONE;
               end else if (mode) begin
                  if (num_hi >= divisor) begin
                     eo_q <= 1'b1;
                     st_q <= ST_DONE;
                  end else begin
                     st_q <= ST_DIV;
                  end
               end else if (len == '0) begin
                  st_q <= ST_DONE;
               end else begin
                  st_q <= ST_FETCH;
               end
            end
            ST_FETCH: st_q <= ST_WAIT;
            ST_WAIT:  if (rvalid) st_q <= ST_DIV;
            ST_DIV: if (fin) begin
               if (op_q == OP_PAIR) begin
                  quot_q <= dq_quo;
                  rem_q  <= RW'(dq_rem);
                  st_q   <= ST_DONE;
               end else begin
                  run_q <= dq_rem;
                  if (last) begin
                     rem_q <= RW'(dq_rem);
                     st_q  <= ST_DONE;
                  end else begin
                     st_q <= ST_FETCH;
                  end
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd   = (st_q == ST_FETCH);
   assign busy     = !idle;
   assign done     = (st_q == ST_DONE);
   assign rem_out  = rem_q;
   assign quot_out = quot_q;
   assign err_div0 = e0_q;
   assign err_ovf  = eo_q;

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   div0_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_div0) |-> done);

   // R7
   div0_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> !err_div0);

   // R6
   ovf_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_ovf) |-> (done && !mem_rd));

   // R4
   rem_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rem_out[RW-1:W] == '0));

endmodule

// File: tb/test_wordmod_unit.sv
`timescale 1ns/1ps
module test_wordmod_unit;
   localparam int W  = 16;
   localparam int AW = 16;
   localparam int LW = 16;
   localparam int RL = 1;
   localparam int PER_WORD = W + RL + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          mode = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [LW-1:0] len = '0;
   logic [W-1:0]  divisor = '0, num_hi = '0, num_lo = '0;
   logic          mem_rd;
   logic [AW-1:0] mem_addr;
   logic [W-1:0]  mem_rdata;
   logic          busy, done, err_div0, err_ovf;
   logic [2*W-1:0] rem_out;
   logic [W-1:0]  quot_out;

   always #2.5 clk = ~clk;

   wordmod_unit #(.W(W), .AW(AW), .LW(LW), .RD_LAT(RL)) i_wordmod_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .base_addr(base_addr), .len(len), .divisor(divisor),
      .num_hi(num_hi), .num_lo(num_lo), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy),
      .done(done), .rem_out(rem_out), .quot_out(quot_out),
      .err_div0(err_div0), .err_ovf(err_ovf)
   );

   // memory model and read log
   logic [W-1:0]  mem [0:255];
   logic [AW-1:0] rd_log [0:63];
   int            rd_total = 0;
   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= mem[mem_addr[7:0]];
         rd_log[rd_total % 64] <= mem_addr;
         rd_total <= rd_total + 1;
      end
   end

   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // {hi, lo, divisor, quotient, remainder}
   localparam logic [79:0] VEC [8] = '{
      {16'h0000, 16'h0064, 16'h0007, 16'h000E, 16'h0002},
      {16'h0001, 16'h0000, 16'h0002, 16'h8000, 16'h0000},
      {16'h0003, 16'h0000, 16'h0004, 16'hC000, 16'h0000},
      {16'h1234, 16'h5678, 16'hFFFF, 16'h1234, 16'h68AC},
      {16'hFFFE, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFE},
      {16'h0000, 16'hABCD, 16'h0001, 16'hABCD, 16'h0000},
      {16'h0000, 16'h0005, 16'h0009, 16'h0000, 16'h0005},
      {16'h0000, 16'hFFFF, 16'h0100, 16'h00FF, 16'h00FF}
   };

   logic [2*W-1:0] r_rem;
   logic [W-1:0]   r_quot;
   logic           r_e0, r_eo;
   int             r_lat, r_rd0;

   task automatic run_op(input logic md, input logic [AW-1:0] b,
                         input logic [LW-1:0] ln, input logic [W-1:0] dv,
                         input logic [W-1:0] hi, input logic [W-1:0] lo,
                         input bit inject);
      @(negedge clk);
      mode = md; base_addr = b; len = ln; divisor = dv;
      num_hi = hi; num_lo = lo; start = 1'b1;
      r_rd0 = rd_total;
      @(negedge clk);
      start = 1'b0;
      r_lat = 0;
      while (1) begin
         r_lat++;
         if (done) break;
         if (r_lat > 3000) begin
            chk(1'b0, "watchdog-op", r_lat, 0);
            break;
         end
         if (inject && r_lat == 5) begin
            start = 1'b1; mode = 1'b1; divisor = 16'h0003;
            num_hi = 16'h0000; num_lo = 16'h0010;
         end
         if (inject && r_lat == 6) start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      r_rem = rem_out; r_quot = quot_out; r_e0 = err_div0; r_eo = err_ovf;
   endtask

   task automatic chain_case(input logic [AW-1:0] b, input int ln,
                             input logic [W-1:0] dv, input bit inject);
      logic [255:0] big;
      logic [255:0] expv;
      int nbad_rd;
      big = '0;
      for (int i = 0; i < ln; i++) mem[b[7:0] + i] = W'($urandom);
      for (int i = ln - 1; i >= 0; i--) big = (big << W) | 256'(mem[b[7:0] + i]);
      expv = big % 256'(dv);
      run_op(1'b0, b, LW'(ln), dv, '0, '0, inject);
      chk(r_rem == 32'(expv), "R1 chain remainder", r_rem, expv[63:0]);
      chk(r_rem[2*W-1:W] == '0 && r_quot == '0, "R4 zero upper/quotient",
          {r_rem, r_quot}, {16'h0, expv[31:0], 16'h0});
      nbad_rd = 0;
      for (int i = 0; i < ln; i++)
         if (rd_log[(r_rd0 + i) % 64] != b + AW'(ln - 1 - i)) nbad_rd++;
      chk(rd_total - r_rd0 == ln && nbad_rd == 0, "R2 read order",
          rd_total - r_rd0, ln);
      chk(r_lat == ln * PER_WORD + 1, inject ? "R10 ignored start latency" :
          "R8 chain latency", r_lat, ln * PER_WORD + 1);
   endtask

   initial begin
      #(5.0 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(7));
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !done && !mem_rd && !err_div0 && !err_ovf &&
          rem_out == '0 && quot_out == '0, "R11 reset state",
          {busy, done, mem_rd, err_div0, err_ovf}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5 double-word table
      for (int k = 0; k < 8; k++) begin
         run_op(1'b1, '0, '0, VEC[k][47:32], VEC[k][79:64], VEC[k][63:48], 1'b0);
         chk(r_quot == VEC[k][31:16] && r_rem == 32'(VEC[k][15:0]) && !r_eo,
             "R5 pair divide", {r_quot, r_rem}, {VEC[k][31:16], 16'h0, VEC[k][15:0]});
         chk(r_lat == W + 2, "R8 pair latency", r_lat, W + 2);
      end

      // R1 random chains, including single word and divisor of one
      chain_case(16'd10, 1, 16'h1234, 1'b0);
      chain_case(16'd20, 3, 16'h00FB, 1'b0);
      chain_case(16'd40, 5, 16'hFFFF, 1'b0);
      chain_case(16'd60, 8, W'($urandom) | 16'h0001, 1'b0);
      chain_case(16'd80, 16, W'($urandom) | 16'h8000, 1'b0);
      chain_case(16'd100, 4, 16'h0001, 1'b0);
      chain_case(16'd120, 6, 16'h0002, 1'b0);
      chain_case(16'd140, 1, 16'h0001, 1'b0);

      // R10 start while busy has no effect
      chain_case(16'd160, 2, 16'h0ABC, 1'b1);

      // R9 zero length
      begin
         int rd0;
         rd0 = rd_total;
         run_op(1'b0, 16'd5, '0, 16'h0007, '0, '0, 1'b0);
         chk(r_lat == 1 && r_rem == '0 && rd_total == rd0, "R9 zero length",
             {r_lat, r_rem}, 64'h1_0000_0000);
      end

      // R7 zero divisor, both modes
      begin
         int rd0;
         rd0 = rd_total;
         run_op(1'b0, 16'd10, 16'd3, '0, '0, '0, 1'b0);
         chk(r_e0 && !r_eo && r_lat == 1 && r_rem == '0 && rd_total == rd0,
             "R7 zero divisor chain", {r_e0, r_lat}, {1'b1, 32'd1});
         run_op(1'b1, '0, '0, '0, 16'h0000, 16'h0055, 1'b0);
         chk(r_e0 && r_lat == 1 && r_quot == '0 && r_rem == '0,
             "R7 zero divisor pair", {r_e0, r_lat}, {1'b1, 32'd1});
      end

      // R6 overflow, equal and greater
      run_op(1'b1, '0, '0, 16'h0040, 16'h0040, 16'h0001, 1'b0);
      chk(r_eo && !r_e0 && r_lat == 1 && r_quot == '0 && r_rem == '0,
          "R6 overflow equal", {r_eo, r_lat}, {1'b1, 32'd1});
      run_op(1'b1, '0, '0, 16'h0040, 16'hFFFF, 16'h0001, 1'b0);
      chk(r_eo && r_lat == 1, "R6 overflow greater", {r_eo, r_lat}, {1'b1, 32'd1});

      // R6/R7 flags clear on the next good operation
      run_op(1'b1, '0, '0, 16'h0007, 16'h0000, 16'h0064, 1'b0);
      chk(!r_eo && !r_e0 && r_quot == 16'h000E && r_rem == 32'h2,
          "R6 flags cleared", {r_eo, r_e0, r_quot}, {2'b00, 16'h000E});

      @(negedge clk);
      chk(!busy && !done, "R8 idle after done", {busy, done}, 0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule